// File: doc/BRIEF.md
# Interrupt Wakeup Generator

This block sits between a wide vector of shared peripheral interrupt lines and a downstream interrupt distributor. Each incoming line is forwarded to the distributor through one register stage. The forwarded lines do not depend on any enable setting. Two of the lines are tied to board-level pins that are active low. The block flips their polarity, so the distributor sees every line as active high.

For each of two CPUs, the block holds a bank of enable words, with one bit per interrupt line. It raises a wakeup request for a CPU when any polarity-corrected line is active and that CPU's enable bit for the line is set. A single mode bit chooses how the two cores leave low-power states. When the bit is clear, the cores wake as a pair, and both requests are the OR of the two per-CPU results. When the bit is set, each core wakes on its own enables only.

Software reaches the enable words and the mode bit over a plain read/write bus with byte addresses. Read data is registered.

Top module: `wkgen_top`

## Requirements
- R1: After reset, every enable bit is 0 and the mode bit is 0. While reset is held, `irq_out`, `wake_out` and `bus_rdata` are 0, and they are still 0 in the first cycle after reset is released.
- R2: CPU0 enable word k sits at byte address 4*k. CPU1 enable word k sits at 0x400 + 4*k. A write takes effect at the clock edge where `bus_wr` is sampled. The data for a read appears on `bus_rdata` in the cycle after `bus_rd` is sampled. In any cycle that follows one without a read, `bus_rdata` is 0.
- R3: Interrupt line n is controlled by bit n mod 32 of enable word n/32 (integer division).
- R4: In each cycle, `irq_out` equals the previous cycle's `irq_in`, with lines 7 and 119 excepted. The enable bits and the mode bit have no effect on `irq_out`.
- R5: Lines 7 and 119 are inverted on the way to `irq_out`. The wakeup logic also uses the inverted value of these two lines.
- R6: The per-CPU hit is the OR, over all lines, of the corrected line AND that CPU's enable bit. `wake_out` follows the hits with a delay of one register.
- R7: The mode bit is bit 5 of the word at byte address 0x800, and every other bit of that word reads as 0. With the mode bit at 0, `wake_out[0]` and `wake_out[1]` both equal hit0 OR hit1. With the mode bit at 1, `wake_out[c]` equals hit c.
- R8: The following addresses are unmapped: any address whose low two bits are not 0, any enable index at or above NUM_BANKS, any address at or above 0xC00, and any address from 0x800 to 0xBFF other than 0x800. A read from an unmapped address returns 0. A write to one changes no register.
- R9: Writing 0x00000000 to an enable word disables all 32 of its lines as wakeup sources. Writing 0xFFFFFFFF enables all 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | 32*NUM_BANKS | Incoming interrupt lines |
| irq_out | output | 32*NUM_BANKS | Registered, polarity-corrected lines to the distributor |
| wake_out | output | 2 | Registered wakeup request, one bit per CPU |

## Verification
The assertions assume that `irq_in` and the bus signals are synchronous to `clk` and stable around the rising edge. They also assume that reset is held for at least one edge, and that both inverted pin positions lie inside the line vector. The bench changes every input only on the falling edge and never raises `bus_rd` and `bus_wr` in the same cycle, so read data never depends on how a same-cycle write is ordered. The random phase mixes mapped and unmapped addresses and uses wide random line patterns. It toggles the mode bit during the run, so both wake policies are exercised while the enables change.

// File: rtl/wkgen_pkg.sv
package wkgen_pkg;
  localparam int WORD_W   = 32;
  localparam int ADDR_W   = 12;
  localparam int MODE_BIT = 5;

  typedef enum logic [1:0] {
    RGN_CPU0 = 2'd0,
    RGN_CPU1 = 2'd1,
    RGN_MODE = 2'd2,
    RGN_NONE = 2'd3
  } region_e;
endpackage

// File: rtl/wkgen_addr_dec.sv
module wkgen_addr_dec
  import wkgen_pkg::*;
#(
  parameter int NUM_BANKS = 5,
  localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output region_e           region,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output logic [1:0]        cpu_wr,
  output logic              mode_wr
);
  logic aligned;
  logic idx_ok;
  logic mode_ok;

  assign aligned = (addr[1:0] == 2'b00);
  assign idx_ok  = ({24'b0, addr[9:2]} < 32'(NUM_BANKS));
  assign mode_ok = (addr[9:0] == 10'd0);
  assign region  = region_e'(addr[11:10]);
  assign idx     = addr[2 +: IDX_W];

  always_comb begin
    hit = 1'b0;
    unique case (region)
      RGN_CPU0, RGN_CPU1: hit = aligned && idx_ok;
      RGN_MODE:           hit = mode_ok;
      default:            hit = 1'b0;
    endcase
  end

  assign cpu_wr[0] = wr && hit && (region == RGN_CPU0);
  assign cpu_wr[1] = wr && hit && (region == RGN_CPU1);
  assign mode_wr   = wr && hit && (region == RGN_MODE);
endmodule

// File: rtl/wkgen_enable_bank.sv
module wkgen_enable_bank
  import wkgen_pkg::*;
#(
  parameter int NUM_BANKS = 5,
  localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int LINES = WORD_W * NUM_BANKS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rd_word,
  output logic [LINES-1:0]  en_flat
);
  logic [WORD_W-1:0] words [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        words[b] <= '0;
      end else if (wr_en && (idx == IDX_W'(b))) begin
        words[b] <= wdata;
      end
    end
    assign en_flat[b*WORD_W +: WORD_W] = words[b];
  end

  always_comb begin
    rd_word = '0;
    if (int'(idx) < NUM_BANKS) rd_word = words[idx];
  end
endmodule

// File: rtl/wkgen_polarity.sv
module wkgen_polarity #(
  parameter int LINES = 160,
  parameter int PIN_A = 7,
  parameter int PIN_B = 119
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] irq_in,
  output logic [LINES-1:0] corr,
  output logic [LINES-1:0] irq_out
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    if (i == PIN_A || i == PIN_B) begin : g_inv
      assign corr[i] = ~irq_in[i];
    end else begin : g_pass
      assign corr[i] = irq_in[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_out <= '0;
    else     irq_out <= corr;
  end
endmodule

// File: rtl/wkgen_wake_reduce.sv
module wkgen_wake_reduce #(
  parameter int LINES = 160
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] lines,
  input  logic [LINES-1:0] en0,
  input  logic [LINES-1:0] en1,
  input  logic             indep,
  output logic [1:0]       wake
);
  logic hit0;
  logic hit1;

  assign hit0 = |(lines & en0);
  assign hit1 = |(lines & en1);

  always_ff @(posedge clk) begin
    if (rst) begin
      wake <= 2'b00;
    end else if (indep) begin
      wake <= {hit1, hit0};
    end else begin
      wake <= {2{hit0 | hit1}};
    end
  end
endmodule

// File: rtl/wkgen_top.sv
module wkgen_top
  import wkgen_pkg::*;
#(
  parameter int NUM_BANKS = 5,
  parameter int EXT_PIN_A = 7,
  parameter int EXT_PIN_B = 119,
  localparam int LINES = WORD_W * NUM_BANKS,
  localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [LINES-1:0]  irq_in,
  output logic [LINES-1:0]  irq_out,
  output logic [1:0]        wake_out
);
  region_e           region;
  logic              hit;
  logic [IDX_W-1:0]  idx;
  logic [1:0]        cpu_wr;
  logic              mode_wr;
  logic              mode_q;
  logic [WORD_W-1:0] rd_word [2];
  logic [LINES-1:0]  en_vec  [2];
  logic [LINES-1:0]  en_cpu0;
  logic [LINES-1:0]  en_cpu1;
  logic [LINES-1:0]  corr;
  logic [WORD_W-1:0] rd_mux;

  wkgen_addr_dec #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .region(region), .hit(hit),
    .idx(idx), .cpu_wr(cpu_wr), .mode_wr(mode_wr)
  );

  for (genvar c = 0; c < 2; c++) begin : g_cpu
    wkgen_enable_bank #(.NUM_BANKS(NUM_BANKS)) u_bank (
      .clk(clk), .rst(rst), .wr_en(cpu_wr[c]), .idx(idx),
      .wdata(bus_wdata), .rd_word(rd_word[c]), .en_flat(en_vec[c])
    );
  end

  assign en_cpu0 = en_vec[0];
  assign en_cpu1 = en_vec[1];

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= 1'b0;
    else if (mode_wr) mode_q <= bus_wdata[MODE_BIT];
  end

  wkgen_polarity #(.LINES(LINES), .PIN_A(EXT_PIN_A), .PIN_B(EXT_PIN_B)) u_pol (
    .clk(clk), .rst(rst), .irq_in(irq_in), .corr(corr), .irq_out(irq_out)
  );

  wkgen_wake_reduce #(.LINES(LINES)) u_wake (
    .clk(clk), .rst(rst), .lines(corr), .en0(en_cpu0), .en1(en_cpu1),
    .indep(mode_q), .wake(wake_out)
  );

  always_comb begin
    rd_mux = '0;
    if (hit) begin
      unique case (region)
        RGN_CPU0: rd_mux = rd_word[0];
        RGN_CPU1: rd_mux = rd_word[1];
        RGN_MODE: rd_mux[MODE_BIT] = mode_q;
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end
endmodule

// File: rtl/wkgen_chk.sv
module wkgen_chk #(
  parameter int LINES = 160,
  parameter int PIN_A = 7,
  parameter int PIN_B = 119
) (
  input logic             clk,
  input logic             rst,
  input logic [LINES-1:0] irq_in,
  input logic [LINES-1:0] irq_out,
  input logic [1:0]       wake_out,
  input logic             bus_rd,
  input logic [31:0]      bus_rdata,
  input logic             mode_q,
  input logic [LINES-1:0] en0,
  input logic [LINES-1:0] en1
);
  logic [LINES-1:0] inv;
  always_comb begin
    inv = '0;
    inv[PIN_A] = 1'b1;
    inv[PIN_B] = 1'b1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (wake_out == 2'b00 && irq_out == '0 && bus_rdata == '0));

  // R4
  passthru_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (irq_out == ($past(irq_in) ^ inv)));

  // R2
  rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));

  // R6
  wake_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (en0 == '0 && en1 == '0) |=> (wake_out == 2'b00));

  // R7
  lockstep_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_q |=> (wake_out[0] == wake_out[1]));
endmodule

bind wkgen_top wkgen_chk #(.LINES(LINES), .PIN_A(EXT_PIN_A), .PIN_B(EXT_PIN_B)) u_chk (
  .clk(clk), .rst(rst), .irq_in(irq_in), .irq_out(irq_out), .wake_out(wake_out),
  .bus_rd(bus_rd), .bus_rdata(bus_rdata), .mode_q(mode_q), .en0(en_cpu0), .en1(en_cpu1)
);

// File: tb/wkgen_top_bench.sv
`timescale 1ns/1ps
module wkgen_top_bench;
  localparam int NB = 5;
  localparam int NL = 32 * NB;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NL-1:0] irq_in = '0;
  logic [NL-1:0] irq_out;
  logic [1:0]    wake_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  wkgen_top #(.NUM_BANKS(NB)) u_wkgen_top (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .irq_out(irq_out), .wake_out(wake_out)
  );

  // reference model
  logic [31:0]   m_en [2][NB];
  logic          m_mode;
  logic [NL-1:0] x_irq;
  logic [1:0]    x_wake;
  logic [31:0]   x_rdata;

  function automatic bit is_inv(int n);
    return (n == 7) || (n == 119);
  endfunction

  // kind: 0 none, 1 cpu0, 2 cpu1, 3 mode
  function automatic int kind_of(logic [11:0] a, output int k);
    int ai;
    ai = int'(a);
    k = 0;
    if (ai % 4 != 0) return 0;
    if (ai < 'h400) begin k = ai / 4; return (k < NB) ? 1 : 0; end
    if (ai < 'h800) begin k = (ai - 'h400) / 4; return (k < NB) ? 2 : 0; end
    if (ai == 'h800) return 3;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 2; c++) for (int k = 0; k < NB; k++) m_en[c][k] = '0;
      m_mode = 1'b0; x_irq = '0; x_wake = 2'b00; x_rdata = '0;
    end else begin
      int kd, k;
      bit h0, h1, ln;
      h0 = 0; h1 = 0;
      for (int n = 0; n < NL; n++) begin
        ln = irq_in[n] ^ is_inv(n);
        x_irq[n] = ln;
        if (ln && m_en[0][n/32][n%32]) h0 = 1;
        if (ln && m_en[1][n/32][n%32]) h1 = 1;
      end
      x_wake = m_mode ? {h1, h0} : {h0 | h1, h0 | h1};
      x_rdata = '0;
      if (bus_rd) begin
        kd = kind_of(bus_addr, k);
        if (kd == 1) x_rdata = m_en[0][k];
        else if (kd == 2) x_rdata = m_en[1][k];
        else if (kd == 3) x_rdata = {26'b0, m_mode, 5'b0};
      end
      if (bus_wr) begin
        kd = kind_of(bus_addr, k);
        if (kd == 1) m_en[0][k] = bus_wdata;
        else if (kd == 2) m_en[1][k] = bus_wdata;
        else if (kd == 3) m_mode = bus_wdata[5];
      end
    end
  end

  always @(posedge clk) begin
    #2;
    checks++;
    if (irq_out !== x_irq) begin
      errors++;
      $display("FAIL R4/R5 irq_out actual=%h expected=%h", irq_out, x_irq);
    end
    checks++;
    if (wake_out !== x_wake) begin
      errors++;
      $display("FAIL R6/R7 wake_out actual=%b expected=%b", wake_out, x_wake);
    end
    checks++;
    if (bus_rdata !== x_rdata) begin
      errors++;
      $display("FAIL R2 bus_rdata actual=%h expected=%h", bus_rdata, x_rdata);
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d cycles expected=<100000", cyc);
      finish_run();
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s read %h actual=%h expected=%h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic set_lines(input logic [NL-1:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
  endtask

  task automatic wake_chk(input logic [1:0] exp, input string tag);
    checks++;
    if (wake_out !== exp) begin
      errors++;
      $display("FAIL %s wake_out actual=%b expected=%b", tag, wake_out, exp);
    end
  endtask

  // inverted pins idle high so they are inactive after correction
  function automatic logic [NL-1:0] idle();
    logic [NL-1:0] v;
    v = '0; v[7] = 1'b1; v[119] = 1'b1;
    return v;
  endfunction

  initial begin
    logic [NL-1:0] v;
    repeat (2) @(negedge clk);
    // R1: outputs during reset
    checks++;
    if (wake_out !== 2'b00 || irq_out !== '0 || bus_rdata !== '0) begin
      errors++;
      $display("FAIL R1 reset outputs actual=%b/%h expected=0", wake_out, irq_out);
    end
    repeat (3) @(negedge clk);
    irq_in = idle();
    rst = 1'b0;
    // R1: registers cleared
    for (int k = 0; k < NB; k++) begin
      rd_chk(12'(4*k), 32'h0, "R1");
      rd_chk(12'('h400 + 4*k), 32'h0, "R1");
    end
    rd_chk(12'h800, 32'h0, "R1");

    // R2: write/readback both CPUs
    wr(12'h004, 32'hA5A5_0001);
    wr(12'h410, 32'h1234_5678);
    rd_chk(12'h004, 32'hA5A5_0001, "R2");
    rd_chk(12'h410, 32'h1234_5678, "R2");
    wr(12'h004, 32'h0);
    wr(12'h410, 32'h0);

    // R7: independent mode, only bit 5 kept
    wr(12'h800, 32'hFFFF_FFFF);
    rd_chk(12'h800, 32'h0000_0020, "R7");

    // R3: line 45 -> word 1 bit 13 on CPU1
    wr(12'h404, 32'h0000_2000);
    v = idle(); v[45] = 1'b1;
    set_lines(v);
    wake_chk(2'b10, "R3");
    v = idle(); v[44] = 1'b1;
    set_lines(v);
    wake_chk(2'b00, "R3");

    // R7: lockstep mode, CPU1 hit wakes both
    wr(12'h800, 32'h0);
    v = idle(); v[45] = 1'b1;
    set_lines(v);
    wake_chk(2'b11, "R7");
    wr(12'h404, 32'h0);
    wr(12'h800, 32'h20);

    // R5: pin 7 driven low is active
    wr(12'h000, 32'h0000_0080);
    v = idle(); v[7] = 1'b0;
    set_lines(v);
    wake_chk(2'b01, "R5");
    checks++;
    if (irq_out[7] !== 1'b1) begin
      errors++; $display("FAIL R5 irq_out[7] actual=%b expected=1", irq_out[7]);
    end
    set_lines(idle());
    wake_chk(2'b00, "R5");
    wr(12'h000, 32'h0);
    // R5: pin 119 on CPU1
    wr(12'h40C, 32'h0080_0000);
    v = idle(); v[119] = 1'b0;
    set_lines(v);
    wake_chk(2'b10, "R5");
    wr(12'h40C, 32'h0);

    // R4: enables have no effect on pass-through
    wr(12'h008, 32'hFFFF_FFFF);
    v = idle(); v[70] = 1'b1; v[3] = 1'b1;
    set_lines(v);
    checks++;
    if (irq_out[70] !== 1'b1 || irq_out[3] !== 1'b1 || irq_out[71] !== 1'b0) begin
      errors++; $display("FAIL R4 irq_out bits actual=%b%b%b expected=110",
                         irq_out[70], irq_out[3], irq_out[71]);
    end

    // R9: all-ones word enables every line of word 2
    wake_chk(2'b01, "R9");
    for (int b = 0; b < 32; b += 9) begin
      v = idle(); v[64 + b] = 1'b1;
      set_lines(v);
      wake_chk(2'b01, "R9");
    end
    wr(12'h008, 32'h0);
    v = idle(); v[64 +: 32] = '1;
    set_lines(v);
    wake_chk(2'b00, "R9");

    // R8: unmapped accesses
    wr(12'h014, 32'hFFFF_FFFF);
    wr(12'h002, 32'hFFFF_FFFF);
    wr(12'hC00, 32'hFFFF_FFFF);
    wr(12'h804, 32'hFFFF_FFFF);
    wr(12'h414, 32'hFFFF_FFFF);
    rd_chk(12'h014, 32'h0, "R8");
    rd_chk(12'hC00, 32'h0, "R8");
    rd_chk(12'h804, 32'h0, "R8");
    rd_chk(12'h001, 32'h0, "R8");
    for (int k = 0; k < NB; k++) begin
      rd_chk(12'(4*k), 32'h0, "R8");
      rd_chk(12'('h400 + 4*k), 32'h0, "R8");
    end
    rd_chk(12'h800, 32'h20, "R8");
    v = '1;
    set_lines(v);
    wake_chk(2'b00, "R8");

    // random phase checked against the model each cycle
    for (int t = 0; t < 600; t++) begin
      int sel;
      @(negedge clk);
      for (int w = 0; w < NB; w++) irq_in[w*32 +: 32] = $urandom() & $urandom();
      bus_wr = 1'b0; bus_rd = 1'b0;
      sel = int'($urandom_range(0, 9));
      bus_wdata = $urandom();
      if (sel < 3) begin
        bus_wr = 1'b1;
        bus_addr = 12'($urandom_range(0, 1) * 'h400 + 4 * $urandom_range(0, NB - 1));
        if ($urandom_range(0, 3) == 0) bus_wdata = '1;
      end else if (sel == 3) begin
        bus_wr = 1'b1; bus_addr = 12'h800;
      end else if (sel == 4) begin
        bus_wr = 1'b1; bus_addr = 12'($urandom());
      end else if (sel < 8) begin
        bus_rd = 1'b1; bus_addr = 12'($urandom_range(0, 1) * 'h400 + 4 * $urandom_range(0, NB + 1));
      end else begin
        bus_rd = 1'b1; bus_addr = 12'($urandom());
      end
    end
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule